// File: doc/BRIEF.md
# Page Write Commit Controller

This controller sits between a two-wire slave engine and a nonvolatile byte store. The engine hands it one strobe per received data byte, together with the byte's target address and value. The engine also signals each START and STOP condition on the bus. The controller gathers the bytes of one write transaction into an eight-slot page buffer.

Nothing reaches the store until the transaction closes with STOP while the write-lock input is low. The buffered bytes are then emitted as single-cycle store write strobes. An internally timed write period follows, during which the controller reports busy and ignores the bus.

Two wiper code registers shadow the store locations F8h and F9h. They are loaded from the store after reset and updated whenever a committed write lands on those addresses. The code shadowing F9h is clamped to a 100-step range. Writes aimed at the reserved locations FAh to FFh are dropped.

Top module: `pgw_commit_ctrl`

## Requirements
- R1: After reset is released, `busy` is high for exactly two cycles. In the first cycle `mem_raddr` is F8h and `wiper1_code` takes `mem_rdata`. In the second cycle `mem_raddr` is F9h and `wiper0_code` takes `mem_rdata`, clamped to 99.
- R2: The first byte of a transaction sets the page to `byte_addr[7:3]` and the slot to `byte_addr[2:0]`. Every later byte goes to the next slot modulo 8, and its `byte_addr` is ignored. A ninth byte therefore overwrites the first one.
- R3: A STOP accepted with `wr_lock` low and at least one byte buffered starts a flush on the next cycle. The flush visits slots 0 to 7 in ascending order, one per cycle. During the flush, `mem_we` pulses for each filled slot, with `mem_waddr` = {page, slot}. `busy` then stays high for WCYC more cycles, so it is high for 8+WCYC cycles in total.
- R4: With `wr_lock` high at STOP, the buffer is discarded. No store write happens, `busy` stays low and both wiper codes are unchanged.
- R5: A START while idle discards any buffered bytes.
- R6: Buffered bytes whose address is FAh or above produce no `mem_we`.
- R7: A committed write to F9h sets `wiper0_code` to the data, clamped to 99.
- R8: A committed write to F8h sets `wiper1_code` to the data unchanged.
- R9: While `busy` is high, byte, START and STOP strobes have no effect.
- R10: A STOP with an empty buffer starts no write and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One received data byte is valid |
| byte_addr | input | 8 | Store address of the byte (only the first byte of a transaction is used) |
| byte_data | input | 8 | Byte value |
| start_stb | input | 1 | START condition seen on the bus |
| stop_stb | input | 1 | STOP condition seen on the bus |
| wr_lock | input | 1 | High blocks all commits (pulled high on the board) |
| mem_rdata | input | 8 | Store read data for `mem_raddr`, combinational |
| mem_raddr | output | 8 | Store read address used during the post-reset load |
| mem_we | output | 1 | Store write strobe |
| mem_waddr | output | 8 | Store write address |
| mem_wdata | output | 8 | Store write data |
| busy | output | 1 | Load or timed write cycle in progress |
| wiper0_code | output | 8 | 100-step wiper code (0 to 99) |
| wiper1_code | output | 8 | 256-step wiper code |

## Verification
A corrupted page base or slot pointer shows at the ports within one cycle of the flush. Either `mem_waddr` lands on the wrong address, or a `mem_we` pulse falls in the wrong one of the eight flush cycles. A stale buffer-filled flag shows as an extra or missing write, or as `busy` wrongly rising after a STOP. A wrong timer count moves the falling edge of `busy`, which is visible exactly 8+WCYC cycles after the STOP. Wiper faults appear on the cycle after the write to F8h or F9h, and a fault in the reset load appears two cycles after reset.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        SQ_LOAD1,
        SQ_LOAD0,
        SQ_IDLE,
        SQ_FLUSH,
        SQ_HOLD
    } seq_state_e;

    typedef struct packed {
        logic              used;
        logic [DATA_W-1:0] data;
    } slot_t;

    function automatic logic [DATA_W-1:0] clamp_code(input logic [DATA_W-1:0] v,
                                                     input logic [DATA_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SLOTS  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cap_en,
    input  logic                      clr,
    input  logic [ADDR_W-1:0]         in_addr,
    input  logic [DATA_W-1:0]         in_data,
    input  logic [$clog2(SLOTS)-1:0]  rd_idx,
    output slot_t                     rd_slot,
    output logic [ADDR_W-$clog2(SLOTS)-1:0] page_base,
    output logic                      any_used
);
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int PAGE_W = ADDR_W - IDX_W;

    slot_t              slots [SLOTS];
    logic               active;
    logic [IDX_W-1:0]   wptr;
    logic [PAGE_W-1:0]  base_q;
    logic [IDX_W-1:0]   tgt;

    assign tgt = active ? wptr : in_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active <= 1'b0;
            wptr   <= '0;
            base_q <= '0;
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
        end else if (cap_en) begin
            if (!active) base_q <= in_addr[ADDR_W-1:IDX_W];
            slots[tgt] <= '{used: 1'b1, data: in_data};
            wptr       <= IDX_W'(tgt + 1'b1);
            active     <= 1'b1;
        end
    end

    always_comb begin
        any_used = 1'b0;
        for (int i = 0; i < SLOTS; i++) any_used = any_used | slots[i].used;
    end

    assign rd_slot   = slots[rd_idx];
    assign page_base = base_q;

    p_clr_empties_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any_used);

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int WCYC  = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stop_stb,
    input  logic                     lock,
    input  logic                     have_data,
    output seq_state_e               state,
    output logic [$clog2(SLOTS)-1:0] idx,
    output logic                     go,
    output logic                     flush_last,
    output logic                     busy
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int TW    = $clog2(WCYC + 1);

    seq_state_e        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TW-1:0]     cnt_q;

    assign go         = (st_q == SQ_IDLE) && stop_stb && have_data && !lock;
    assign flush_last = (st_q == SQ_FLUSH) && (idx_q == IDX_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_LOAD1;
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SQ_LOAD1: st_q <= SQ_LOAD0;
                SQ_LOAD0: st_q <= SQ_IDLE;
                SQ_IDLE: if (go) begin
                    st_q  <= SQ_FLUSH;
                    idx_q <= '0;
                end
                SQ_FLUSH: if (flush_last) begin
                    st_q  <= SQ_HOLD;
                    cnt_q <= TW'(WCYC - 1);
                end else begin
                    idx_q <= IDX_W'(idx_q + 1'b1);
                end
                SQ_HOLD: if (cnt_q == '0) st_q <= SQ_IDLE;
                         else cnt_q <= cnt_q - 1'b1;
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign state = st_q;
    assign idx   = idx_q;
    assign busy  = (st_q != SQ_IDLE);

    p_lock_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_IDLE && stop_stb && lock) |=> (st_q == SQ_IDLE));

    p_hold_runs_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_HOLD && cnt_q != '0) |=> (st_q == SQ_HOLD));

endmodule

// File: rtl/pgw_wiper.sv
module pgw_wiper
    import pgw_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] W0_ADDR = 8'hF9,
    parameter logic [ADDR_W-1:0] W1_ADDR = 8'hF8,
    parameter logic [DATA_W-1:0] W0_TOP  = 8'd99
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load0,
    input  logic              load1,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] w0,
    output logic [DATA_W-1:0] w1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            w0 <= '0;
            w1 <= '0;
        end else begin
            if (load0)                          w0 <= clamp_code(ld_data, W0_TOP);
            else if (wr_en && wr_addr == W0_ADDR) w0 <= clamp_code(wr_data, W0_TOP);
            if (load1)                          w1 <= ld_data;
            else if (wr_en && wr_addr == W1_ADDR) w1 <= wr_data;
        end
    end

    p_w0_cap_r7: assert property (@(posedge clk) disable iff (rst)
        w0 <= W0_TOP);

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !(load0 || load1 || wr_en) |=> ($stable(w0) && $stable(w1)));

endmodule

// File: rtl/pgw_commit_ctrl.sv
module pgw_commit_ctrl
    import pgw_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                SLOTS    = 8,
    parameter int                WCYC     = 1000,
    parameter logic [ADDR_W-1:0] RSV_BASE = 8'hFA,
    parameter logic [ADDR_W-1:0] W0_ADDR  = 8'hF9,
    parameter logic [ADDR_W-1:0] W1_ADDR  = 8'hF8,
    parameter logic [DATA_W-1:0] W0_TOP   = 8'd99
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_stb,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              wr_lock,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] wiper0_code,
    output logic [DATA_W-1:0] wiper1_code
);
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int PAGE_W = ADDR_W - IDX_W;

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic              go, flush_last, any_used, cap_en, clr, idle;
    slot_t             cur;
    logic [PAGE_W-1:0] base;

    assign idle   = !busy;
    assign cap_en = idle && byte_stb && !start_stb && !stop_stb;
    assign clr    = (idle && start_stb) || (idle && stop_stb && !go) || flush_last;

    pgw_page_buf #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) buf_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .clr(clr),
        .in_addr(byte_addr), .in_data(byte_data),
        .rd_idx(idx), .rd_slot(cur), .page_base(base), .any_used(any_used)
    );

    pgw_seq #(.SLOTS(SLOTS), .WCYC(WCYC)) seq_i (
        .clk(clk), .rst(rst), .stop_stb(stop_stb), .lock(wr_lock),
        .have_data(any_used), .state(state), .idx(idx), .go(go),
        .flush_last(flush_last), .busy(busy)
    );

    assign mem_waddr = {base, idx};
    assign mem_wdata = cur.data;
    assign mem_we    = (state == SQ_FLUSH) && cur.used && (mem_waddr < RSV_BASE);
    assign mem_raddr = (state == SQ_LOAD1) ? W1_ADDR :
                       (state == SQ_LOAD0) ? W0_ADDR : '0;

    pgw_wiper #(.ADDR_W(ADDR_W), .W0_ADDR(W0_ADDR), .W1_ADDR(W1_ADDR),
                .W0_TOP(W0_TOP)) wip_i (
        .clk(clk), .rst(rst),
        .load0(state == SQ_LOAD0), .load1(state == SQ_LOAD1), .ld_data(mem_rdata),
        .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata),
        .w0(wiper0_code), .w1(wiper1_code)
    );

    p_we_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !flush_last && state != SQ_HOLD && state != SQ_LOAD0) |=> busy);

endmodule

// File: tb/pgw_commit_ctrl_tb.sv
module pgw_commit_ctrl_tb_top;

    localparam int WCYC = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_stb = 1'b0, start_stb = 1'b0, stop_stb = 1'b0, wr_lock = 1'b0;
    logic [7:0] byte_addr = '0, byte_data = '0;
    logic [7:0] mem_rdata, mem_raddr, mem_waddr, mem_wdata, wiper0_code, wiper1_code;
    logic       mem_we, busy;

    logic [7:0] mem [256];
    int checks = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_raddr];
    always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;

    pgw_commit_ctrl #(.WCYC(WCYC)) dut_i (
        .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_addr(byte_addr),
        .byte_data(byte_data), .start_stb(start_stb), .stop_stb(stop_stb),
        .wr_lock(wr_lock), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .busy(busy), .wiper0_code(wiper0_code), .wiper1_code(wiper1_code)
    );

    // ---------------- behavioural reference ----------------
    typedef struct { bit we; int addr; int data; } wr_ev_t;
    wr_ev_t q[$];
    int  busy_left = 0, init_step = 2;
    int  m_w0 = 0, m_w1 = 0;
    bit  b_used [8];
    int  b_data [8];
    int  b_base = 0, b_ptr = 0;
    bit  b_active = 0;

    function automatic int sat99(input int v);
        return (v > 99) ? 99 : v;
    endfunction

    task automatic buf_clear();
        foreach (b_used[i]) b_used[i] = 0;
        b_active = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            busy_left = 2; init_step = 0; q.delete(); buf_clear();
            m_w0 = 0; m_w1 = 0;
        end else begin
            bit was_busy;
            bit anyb;
            was_busy = (busy_left > 0);
            if (q.size() > 0) begin
                wr_ev_t e;
                e = q.pop_front();
                if (e.we && e.addr == 'hF9) m_w0 = sat99(e.data);
                if (e.we && e.addr == 'hF8) m_w1 = e.data;
            end
            if (init_step == 0) m_w1 = mem['hF8];
            if (init_step == 1) m_w0 = sat99(mem['hF9]);
            if (init_step < 2) init_step++;
            if (busy_left > 0) busy_left--;
            if (!was_busy) begin
                anyb = 0;
                foreach (b_used[i]) anyb |= b_used[i];
                if (start_stb) buf_clear();
                else if (stop_stb) begin
                    if (anyb && !wr_lock) begin
                        for (int s = 0; s < 8; s++) begin
                            wr_ev_t e;
                            e.addr = b_base * 8 + s;
                            e.data = b_data[s];
                            e.we   = b_used[s] && (e.addr < 'hFA);
                            q.push_back(e);
                        end
                        busy_left = 8 + WCYC;
                    end
                    buf_clear();
                end else if (byte_stb) begin
                    int slot;
                    if (!b_active) begin
                        b_base = byte_addr / 8;
                        slot   = byte_addr % 8;
                    end else slot = b_ptr;
                    b_used[slot] = 1; b_data[slot] = byte_data;
                    b_ptr = (slot + 1) % 8; b_active = 1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!rst) begin
            bit ew;
            ew = (q.size() > 0) && q[0].we;
            checks++;
            if (busy !== (busy_left > 0)) begin
                fails++; $display("FAIL R3 busy act=%0b exp=%0b", busy, busy_left > 0);
            end else if (mem_we !== ew) begin
                fails++; $display("FAIL R3 mem_we act=%0b exp=%0b", mem_we, ew);
            end else if (ew && (mem_waddr !== q[0].addr[7:0] || mem_wdata !== q[0].data[7:0])) begin
                fails++; $display("FAIL R2 write act=%02h/%02h exp=%02h/%02h",
                                  mem_waddr, mem_wdata, q[0].addr, q[0].data);
            end else if (wiper0_code !== m_w0[7:0] || wiper1_code !== m_w1[7:0]) begin
                fails++; $display("FAIL R7 R8 wipers act=%0d/%0d exp=%0d/%0d",
                                  wiper0_code, wiper1_code, m_w0, m_w1);
            end else if (init_step < 2 && mem_raddr !== ((init_step == 0) ? 8'hF8 : 8'hF9)) begin
                fails++; $display("FAIL R1 raddr act=%02h step=%0d", mem_raddr, init_step);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); byte_stb = 1; byte_addr = a; byte_data = d;
        @(negedge clk); byte_stb = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_stb = 1;
        @(negedge clk); start_stb = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_stb = 1;
        @(negedge clk); stop_stb = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] snap;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        mem['hF8] = 8'h37; mem['hF9] = 8'hC8;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(busy === 1'b1, "R1 busy after reset", busy, 1);
        wait_idle();
        chk(wiper1_code === 8'h37, "R1 wiper1 load", wiper1_code, 'h37);
        chk(wiper0_code === 8'd99, "R1 wiper0 load clamp", wiper0_code, 99);

        // R3: single byte
        pulse_start(); send_byte(8'h10, 8'hA1); pulse_stop(); wait_idle();
        chk(mem['h10] === 8'hA1, "R3 single byte", mem['h10], 'hA1);

        // R2: eight bytes from mid-page, later addresses ignored
        pulse_start();
        send_byte(8'h23, 8'hB0);
        for (int i = 1; i < 8; i++) send_byte(8'h00, 8'(8'hB0 + i));
        pulse_stop(); wait_idle();
        for (int i = 0; i < 8; i++)
            chk(mem[8'h20 + 8'((3 + i) % 8)] === 8'(8'hB0 + i), "R2 wrap in page",
                mem[8'h20 + 8'((3 + i) % 8)], 8'hB0 + i);

        // R2: ninth byte overwrites first
        pulse_start();
        for (int i = 0; i < 9; i++) send_byte(8'h40, 8'(8'hC0 + i));
        pulse_stop(); wait_idle();
        chk(mem['h40] === 8'hC8, "R2 ninth overwrite", mem['h40], 'hC8);
        chk(mem['h41] === 8'hC1, "R2 second kept", mem['h41], 'hC1);

        // R4: lock high
        snap = mem['h50];
        wr_lock = 1;
        pulse_start(); send_byte(8'h50, 8'hD0); send_byte(8'h51, 8'hF9); pulse_stop();
        @(negedge clk);
        chk(busy === 1'b0, "R4 no busy when locked", busy, 0);
        wait_idle(); wr_lock = 0;
        chk(mem['h50] === snap, "R4 locked store unchanged", mem['h50], snap);

        // R5: START discards
        snap = mem['h60];
        pulse_start(); send_byte(8'h60, 8'hE0); pulse_start(); pulse_stop();
        @(negedge clk);
        chk(busy === 1'b0, "R5 discarded no busy", busy, 0);
        chk(mem['h60] === snap, "R5 discarded store", mem['h60], snap);

        // R10: bare STOP
        pulse_stop(); @(negedge clk);
        chk(busy === 1'b0, "R10 empty stop", busy, 0);

        // R6, R7, R8: page F8h
        pulse_start();
        send_byte(8'hF8, 8'h12); send_byte(8'hF9, 8'h50);
        for (int i = 0; i < 6; i++) send_byte(8'h00, 8'hEE);
        pulse_stop(); wait_idle();
        chk(mem['hF8] === 8'h12, "R8 store F8", mem['hF8], 'h12);
        chk(wiper1_code === 8'h12, "R8 wiper1", wiper1_code, 'h12);
        chk(wiper0_code === 8'h50, "R7 wiper0", wiper0_code, 'h50);
        for (int a = 'hFA; a < 256; a++)
            chk(mem[a] === (8'(a) ^ 8'h5A), "R6 reserved untouched", mem[a], 8'(a) ^ 8'h5A);

        pulse_start(); send_byte(8'hF9, 8'hFF); pulse_stop(); wait_idle();
        chk(wiper0_code === 8'd99, "R7 clamp", wiper0_code, 99);

        // R9: strobes while busy
        snap = mem['h71];
        pulse_start(); send_byte(8'h70, 8'h11); pulse_stop();
        pulse_start(); send_byte(8'h71, 8'h22); pulse_stop();
        wait_idle();
        chk(mem['h70] === 8'h11, "R9 first write", mem['h70], 'h11);
        chk(mem['h71] === snap, "R9 ignored while busy", mem['h71], snap);
        pulse_stop(); @(negedge clk);
        chk(busy === 1'b0, "R9 nothing buffered", busy, 0);

        // R1: reload after a second reset
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        wait_idle();
        chk(wiper1_code === 8'h12, "R1 reload wiper1", wiper1_code, 'h12);
        chk(wiper0_code === 8'd99, "R1 reload wiper0", wiper0_code, 99);

        finish_run();
    end

endmodule